// File: doc/BRIEF.md
# Serial Command and Status Port for a Six-Switch Driver

This block is the digital front end of a bank of six power switches, arranged as three low-side and high-side pairs. An external controller writes a 16-bit command frame through a four-wire serial link. The link has an active-low select, a data-in line, a serial clock that idles low, and a data-out line that the block can release. In the same frame the block returns a 16-bit status word. All serial pins are brought into the system clock domain through a synchronizer and handled there by edge detection, so the serial clock must be well below the system clock.

Command bits arrive least-significant bit first and are sampled on falling serial-clock edges. A command acts only when select is released after exactly sixteen clock pulses. Any other pulse count throws the frame away. The status word is captured when select falls and is shifted out least-significant bit first, changing on rising edges. Sticky fault flags for short circuit, supply fault and overtemperature are set by event inputs and cleared by a command bit. The software-run bit gates the switch enables and has no effect on the serial link.

Top module: `drv_ctrl_spi`

## Requirements
- R1: After reset, all six enables are 0, run is 0, delay select is 0, the open-load-detect control is 1 (detection off), the status-reset pulse is 0 and data-out is disabled.
- R2: A committed frame maps its bits as follows. Bit 0 is status reset. Bits 1..6 are switch enables in the order L1, H1, L2, H2, L3, H3, which map to `sw_en_o[0]..sw_en_o[5]`. Bits 7..12 are ignored. Bit 13 is the open-load-detect control. Bit 14 is delay select. Bit 15 is run.
- R3: Control outputs do not change while a frame is in progress; they change only after select rises.
- R4: A frame that ends with a pulse count other than 16 leaves every control output unchanged.
- R5: `miso_oe_o` is 0 while select is high and 1 during a frame.
- R6: The status word is shifted out bit 0 first, and bit k is valid before the (k+1)-th falling clock edge. Its layout is as follows. Bit 0 is 1 if the previous frame was committed. Bits 1..6 hold the commanded enables. Bits 7..11 are 0. Bit 12 is overtemperature. Bit 13 is short circuit. Bit 14 is the run bit. Bit 15 is supply fault.
- R7: When run is 0, all `sw_en_o` are 0, but frames are still received and committed and the status still echoes the commanded enables.
- R8: A committed frame with bit 0 set gives a one-cycle `stat_rst_o` pulse and clears all three sticky flags.
- R9: A one-cycle pulse on a fault event input sets its sticky flag, which stays set until it is cleared as in R8.
- R10: `ol_det_n_o` follows bit 13 without inversion, so 0 means detection on, and `dly_sel_o` follows bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| mosi_i | input | 1 | Serial command data |
| miso_o | output | 1 | Serial status data |
| miso_oe_o | output | 1 | Output enable for the data-out pad |
| fault_evt_i | input | 3 | Fault events {supply, short, overtemp} |
| sw_en_o | output | 6 | Gated switch enables |
| ol_det_n_o | output | 1 | Open-load detect control, active low |
| dly_sel_o | output | 1 | Fault delay select |
| run_o | output | 1 | Software run (0 = standby) |
| stat_rst_o | output | 1 | One-cycle status-reset pulse |

## Verification
The assertions assume four things about the inputs. Each serial pin holds its level for several system clocks. Data-in is stable around every falling clock edge. Select changes only while the serial clock is low. Fault events are single-cycle pulses. The bench drives each serial half-period as eight system clocks and changes data-in only with the rising clock. It also keeps select transitions clear of clock edges by several cycles. The bench never pulses a fault event in the same cycle as a status clear, so the precedence between set and clear is not exercised.

// File: rtl/drv_spi_pkg.sv
package drv_spi_pkg;
  localparam int FRAME_W = 16;
  localparam int N_SW    = 6;
  localparam int N_FLT   = 3;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  // command field positions (decoded by the controller)
  localparam int C_SRR = 0;
  localparam int C_EN0 = 1;
  localparam int C_OLD = 13;
  localparam int C_DLY = 14;
  localparam int C_RUN = 15;
  // status field positions
  localparam int S_LAST = 0;
  localparam int S_EN0  = 1;
  localparam int S_OT   = 12;
  localparam int S_SC   = 13;
  localparam int S_RUN  = 14;
  localparam int S_PSF  = 15;
  // fault vector order
  localparam int F_OT  = 0;
  localparam int F_SC  = 1;
  localparam int F_PSF = 2;
endpackage

// File: rtl/drv_spi_sync.sv
module drv_spi_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] pipe [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k <= STAGES; k++) pipe[k] <= '0;
    end else begin
      pipe[0] <= d_i;
      for (int k = 1; k <= STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign q_o    = pipe[STAGES-1];
  assign prev_o = pipe[STAGES];
endmodule

// File: rtl/drv_spi_frame.sv
module drv_spi_frame
  import drv_spi_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_act_i,
  input  logic               cs_act_prev_i,
  input  logic               sclk_i,
  input  logic               sclk_prev_i,
  input  logic               mosi_i,
  input  logic [FRAME_W-1:0] status_i,
  output logic               miso_o,
  output logic               miso_oe_o,
  output logic [FRAME_W-1:0] word_o,
  output logic               commit_o,
  output logic               end_o
);
  logic               cs_fall, cs_rise, sck_rise, sck_fall;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] rx_q, tx_q;
  logic               oe_q, commit_q, end_q;

  assign cs_fall  = cs_act_i & ~cs_act_prev_i;
  assign cs_rise  = ~cs_act_i & cs_act_prev_i;
  assign sck_rise = cs_act_i & sclk_i & ~sclk_prev_i;
  assign sck_fall = cs_act_i & ~sclk_i & sclk_prev_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      oe_q     <= 1'b0;
      commit_q <= 1'b0;
      end_q    <= 1'b0;
      word_o   <= '0;
    end else begin
      oe_q     <= cs_act_i;
      commit_q <= 1'b0;
      end_q    <= cs_rise;
      if (cs_fall) begin
        cnt_q <= '0;
        tx_q  <= status_i;
      end else begin
        if (sck_fall) begin
          rx_q <= {mosi_i, rx_q[FRAME_W-1:1]};
          if (cnt_q != CNT_W'(FRAME_W + 1)) cnt_q <= cnt_q + 1'b1;
        end
        if (sck_rise && cnt_q != '0) tx_q <= {1'b0, tx_q[FRAME_W-1:1]};
      end
      if (cs_rise && cnt_q == CNT_W'(FRAME_W)) begin
        commit_q <= 1'b1;
        word_o   <= rx_q;
      end
    end
  end

  assign miso_o    = tx_q[0];
  assign miso_oe_o = oe_q;
  assign commit_o  = commit_q;
  assign end_o     = end_q;

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(FRAME_W + 1));
  p_commit_ends_r4: assert property (@(posedge clk) disable iff (rst)
    commit_q |-> end_q);
endmodule

// File: rtl/drv_spi_faults.sv
module drv_spi_faults
  import drv_spi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_FLT-1:0] evt_i,
  input  logic             clr_i,
  output logic [N_FLT-1:0] flag_o
);
  logic [N_FLT-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~{N_FLT{clr_i}}) | evt_i;
  end
  assign flag_o = flag_q;

  p_sticky_set_r9: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && evt_i == '0) |=> (flag_q == '0));
endmodule

// File: rtl/drv_spi_ctrl.sv
module drv_spi_ctrl
  import drv_spi_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               commit_i,
  input  logic               end_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic [N_SW-1:0]    en_cmd_o,
  output logic [N_SW-1:0]    sw_en_o,
  output logic               ol_det_n_o,
  output logic               dly_sel_o,
  output logic               run_o,
  output logic               srr_o,
  output logic               last_ok_o
);
  logic [N_SW-1:0] en_cmd_q, en_q;
  logic            ol_q, dly_q, run_q, srr_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_cmd_q <= '0;
      en_q     <= '0;
      ol_q     <= 1'b1;
      dly_q    <= 1'b0;
      run_q    <= 1'b0;
      srr_q    <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      srr_q <= 1'b0;
      if (end_i) last_q <= commit_i;
      if (commit_i) begin
        en_cmd_q <= word_i[C_EN0 +: N_SW];
        en_q     <= word_i[C_RUN] ? word_i[C_EN0 +: N_SW] : '0;
        ol_q     <= word_i[C_OLD];
        dly_q    <= word_i[C_DLY];
        run_q    <= word_i[C_RUN];
        srr_q    <= word_i[C_SRR];
      end
    end
  end

  assign en_cmd_o   = en_cmd_q;
  assign sw_en_o    = en_q;
  assign ol_det_n_o = ol_q;
  assign dly_sel_o  = dly_q;
  assign run_o      = run_q;
  assign srr_o      = srr_q;
  assign last_ok_o  = last_q;

  p_inhibit_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (en_q != '0) |-> run_q);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> ($stable(en_cmd_q) && $stable(run_q) && $stable(ol_q) && $stable(dly_q)));
  p_srr_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    srr_q |=> !srr_q);
endmodule

// File: rtl/drv_ctrl_spi.sv
module drv_ctrl_spi
  import drv_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n_i,
  input  logic             sclk_i,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe_o,
  input  logic [N_FLT-1:0] fault_evt_i,
  output logic [N_SW-1:0]  sw_en_o,
  output logic             ol_det_n_o,
  output logic             dly_sel_o,
  output logic             run_o,
  output logic             stat_rst_o
);
  logic [2:0]         pin_q, pin_prev;
  logic [FRAME_W-1:0] word, status;
  logic               commit, frame_end, last_ok;
  logic [N_SW-1:0]    en_cmd;
  logic [N_FLT-1:0]   flags;

  drv_spi_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({mosi_i, sclk_i, ~cs_n_i}),
    .q_o(pin_q), .prev_o(pin_prev)
  );

  always_comb begin
    status                    = '0;
    status[S_LAST]            = last_ok;
    status[S_EN0 +: N_SW]     = en_cmd;
    status[S_OT]              = flags[F_OT];
    status[S_SC]              = flags[F_SC];
    status[S_RUN]             = run_o;
    status[S_PSF]             = flags[F_PSF];
  end

  drv_spi_frame u_frame (
    .clk(clk), .rst(rst),
    .cs_act_i(pin_q[0]), .cs_act_prev_i(pin_prev[0]),
    .sclk_i(pin_q[1]), .sclk_prev_i(pin_prev[1]),
    .mosi_i(pin_q[2]),
    .status_i(status),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .word_o(word), .commit_o(commit), .end_o(frame_end)
  );

  drv_spi_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .commit_i(commit), .end_i(frame_end), .word_i(word),
    .en_cmd_o(en_cmd), .sw_en_o(sw_en_o),
    .ol_det_n_o(ol_det_n_o), .dly_sel_o(dly_sel_o),
    .run_o(run_o), .srr_o(stat_rst_o), .last_ok_o(last_ok)
  );

  drv_spi_faults u_faults (
    .clk(clk), .rst(rst),
    .evt_i(fault_evt_i), .clr_i(stat_rst_o),
    .flag_o(flags)
  );
endmodule

// File: tb/test_drv_ctrl_spi.sv
module test_drv_ctrl_spi;
  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, ol_n, dly, run, srr;
  logic [2:0] evt = '0;
  logic [5:0] sw_en;
  int checks = 0, fails = 0;
  bit done = 0;

  // expected model state
  logic [5:0] m_en = '0;
  logic m_run = 0, m_dly = 0, m_ol = 1, m_last = 0;
  logic [2:0] m_flt = '0;
  logic srr_seen;

  always #10 clk = ~clk;

  drv_ctrl_spi i_drv_ctrl_spi (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .fault_evt_i(evt),
    .sw_en_o(sw_en), .ol_det_n_o(ol_n), .dly_sel_o(dly),
    .run_o(run), .stat_rst_o(srr)
  );

  always @(posedge clk) if (srr) srr_seen <= 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status();
    logic [15:0] s = '0;
    s[0] = m_last; s[6:1] = m_en; s[12] = m_flt[0];
    s[13] = m_flt[1]; s[14] = m_run; s[15] = m_flt[2];
    return s;
  endfunction

  task automatic frame(input logic [15:0] d, input int nbits, output logic [15:0] got,
                       output logic oe_mid, output logic [5:0] en_mid);
    got = '0; oe_mid = 0; en_mid = '0;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? d[i] : 1'b0;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      if (i < 16) got[i] = miso;
      if (i == 8) begin oe_mid = miso_oe; en_mid = sw_en; end
      sclk = 1'b0;
      repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic model_commit(input logic [15:0] d, input int nbits);
    if (nbits == 16) begin
      m_en = d[6:1]; m_run = d[15]; m_dly = d[14]; m_ol = d[13];
      if (d[0]) m_flt = '0;
      m_last = 1;
    end else m_last = 0;
  endtask

  task automatic run_frame(input string tag, input logic [15:0] d, input int nbits);
    logic [15:0] got, es;
    logic oe_mid;
    logic [5:0] en_before, en_mid;
    es = exp_status();
    en_before = sw_en;
    srr_seen = 0;
    frame(d, nbits, got, oe_mid, en_mid);
    chk({tag, " R6 status"}, got, es);
    chk({tag, " R5 oe in frame"}, oe_mid, 1);
    chk({tag, " R3 no mid-frame change"}, en_mid, en_before);
    model_commit(d, nbits);
    chk({tag, " R2/R7 enables"}, sw_en, m_run ? m_en : 6'd0);
    chk({tag, " R10 misc"}, {run, dly, ol_n}, {m_run, m_dly, m_ol});
    chk({tag, " R5 oe idle"}, miso_oe, 0);
    chk({tag, " R8 srr pulse"}, srr_seen, (nbits == 16) && d[0]);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 enables", sw_en, 0);
    chk("R1 misc", {run, dly, ol_n, srr, miso_oe}, 5'b00100);

    // R2 R7 R10 sweep: every enable pattern, run off and on; bits 7..12 noise ignored
    for (int r = 0; r < 2; r++)
      for (int e = 0; e < 64; e++) begin
        logic [15:0] w;
        w = '0;
        w[6:1] = 6'(e); w[15] = r[0]; w[14] = e[0]; w[13] = e[1];
        w[12:7] = 6'(e ^ 6'h2a);
        run_frame("sweep", w, 16);
      end

    // R4 short and long frames discarded
    run_frame("R4 short", 16'h0000, 15);
    run_frame("R4 long", 16'h0000, 17);
    run_frame("R4 recover", 16'h807e, 16);

    // R9 sticky set by event pulses
    for (int f = 0; f < 3; f++) begin
      @(negedge clk); evt = 3'(1 << f);
      @(negedge clk); evt = '0;
      m_flt[f] = 1;
      repeat (20) @(negedge clk);
      run_frame("R9 sticky", 16'h8002, 16);
    end
    // R8 clear via status reset bit, then confirm cleared in next status
    run_frame("R8 clear", 16'h8003, 16);
    run_frame("R8 after", 16'h2000, 16);
    chk("R8 flags cleared", m_flt, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done"); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule